// File: doc/BRIEF.md
# Program/Verify Address Counter and Write Latch Controller

This block keeps the address pointer and write-control state of a flash microcontroller while it is held in serial program/verify mode. A command shifter upstream decodes the serial stream into one-cycle strobes: mode reset, load-configuration, increment, load-data, internally or externally timed begin-programming, end-programming, row erase, program-memory bulk erase and data-memory bulk erase. The block turns these into a 14-bit program counter, a bank of four write latches, and one-cycle write and erase requests, with addresses and erase masks, for a simple memory model.

The counter runs in one of two halves of the address space. It starts in user space after mode entry. A load-configuration command moves it into configuration space, and it stays there until the next mode reset. Writes always commit a four-word block aligned to a multiple of four. Which regions a bulk erase clears depends on where the counter points. The block models erase and internally timed write durations as parameterised cycle counts. It ignores new commands while an operation is in progress.

Top module: `pgm_addr_ctrl`

## Requirements
- R1: A mode reset strobe (mode_rst_i) sets the counter to 0x0000 and all four latches to 0x3FFF. It also ends any operation in progress, so busy_o is low in the next cycle.
- R2: When the counter is below 0x2000, an increment adds one, and incrementing 0x1FFF gives 0x0000.
- R3: A load-configuration strobe sets the counter to 0x2000. After that, bit 13 stays 1 until a mode reset, and incrementing 0x3FFF gives 0x2000.
- R4: A load-data strobe writes data_i into latch number pc[1:0]. A begin strobe (either timing) produces a one-cycle wr_req_o. With it, wr_addr_o is the counter with its two low bits cleared, and wr_data_o holds latch 0 in bits 13:0, latch 1 in bits 27:14, latch 2 in bits 41:28 and latch 3 in bits 55:42.
- R5: A commit made while the counter is below 0x2000 returns all latches to 0x3FFF. A commit made in configuration space leaves the latches unchanged, so four loads of 0x3FFF are needed to clear them.
- R6: A row erase strobe produces a one-cycle row_erase_o with row_sel_o equal to pc[11:4]. It has no effect (no pulse, busy_o stays low) when code_prot_i is 1 or pc[13] is 1.
- R7: A program bulk erase produces a one-cycle bulk_erase_o. The erase_mask_o bits are: bit 0 program memory, bit 1 configuration word, bit 2 user IDs, bit 3 calibration words, bit 4 data memory. Bits 0 and 1 are always set. Bit 2 is also set when the counter is 0x2000. Bits 2 and 3 are also set when the counter is 0x2008 or 0x2009.
- R8: With data_prot_i at 1, a program bulk erase also sets mask bit 4, and a data bulk erase is refused: no pulse, and busy_o stays low. With data_prot_i at 0, a data bulk erase gives mask 0x10.
- R9: After an internally timed begin, busy_o is high for PROG_CYC cycles. After an accepted erase, it is high for ERASE_CYC cycles. Command strobes that arrive while busy_o is high have no effect.
- R10: After an externally timed begin, busy_o and wr_active_o stay high until an end-programming strobe. They go low in the cycle after that strobe.
- R11: If several strobes arrive in the same idle cycle, only one is acted on, in this priority order: load-configuration, increment, load-data, internal begin, external begin, row erase, program bulk erase, data bulk erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_rst_i | input | 1 | Program/verify mode entry or exit strobe |
| ld_cfg_i | input | 1 | Load-configuration strobe |
| incr_i | input | 1 | Increment-address strobe |
| ld_data_i | input | 1 | Load-data strobe |
| data_i | input | 14 | Data word for load-data |
| begin_int_i | input | 1 | Begin programming, internally timed |
| begin_ext_i | input | 1 | Begin programming, externally timed |
| end_pgm_i | input | 1 | End-programming strobe |
| row_erase_i | input | 1 | Row erase strobe |
| bulk_prog_i | input | 1 | Program-memory bulk erase strobe |
| bulk_data_i | input | 1 | Data-memory bulk erase strobe |
| code_prot_i | input | 1 | Program code protection active |
| data_prot_i | input | 1 | Data code protection active |
| pc_o | output | 14 | Program counter |
| busy_o | output | 1 | Operation in progress |
| wr_active_o | output | 1 | Write in progress |
| wr_req_o | output | 1 | One-cycle write request |
| wr_addr_o | output | 14 | Aligned block address of last write |
| wr_data_o | output | 56 | Four latch words of last write |
| row_erase_o | output | 1 | One-cycle row erase request |
| row_sel_o | output | 8 | Row index of last row erase |
| bulk_erase_o | output | 1 | One-cycle bulk erase request |
| erase_mask_o | output | 5 | Regions of last bulk erase |

## Verification
Assertions check, on every cycle, the following properties:
- Configuration space is never left except by a mode reset.
- The counter wraps correctly in user space.
- The counter does not move while busy.
- Request pulses last one cycle.
- Latches clear after user-space commits.
- No row erase is issued outside user space.

The following behaviours can only be shown by the bench's scenarios, against its behavioural model:
- The busy durations.
- The mask chosen for each counter position.
- Latches that persist through configuration-space commits.
- Protection refusals.
- Priority between simultaneous strobes.
- A mode reset that aborts an erase.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [3:0] {
    C_NONE, C_LDCFG, C_INC, C_LDDAT, C_BEGI, C_BEGE, C_ROW, C_BULKP, C_BULKD
  } cmd_e;

  typedef enum logic [1:0] {S_IDLE, S_WR_INT, S_WR_EXT, S_ERASE} state_e;

  localparam int unsigned MASK_W = 5;
  localparam int unsigned M_PROG = 0;
  localparam int unsigned M_CFGW = 1;
  localparam int unsigned M_UID  = 2;
  localparam int unsigned M_CAL  = 3;
  localparam int unsigned M_DATA = 4;
endpackage

// File: rtl/pgm_pc.sv
module pgm_pc
  import pgm_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_rst_i,
  input  cmd_e          cmd_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] CFG_BASE = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] USR_TOP  = {1'b0, {(AW-1){1'b1}}};

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else if (mode_rst_i) pc_q <= '0;
    else begin
      case (cmd_i)
        C_LDCFG: pc_q <= CFG_BASE;
        // top bit is held, so each half wraps onto itself
        C_INC:   pc_q <= {pc_q[AW-1], pc_q[AW-2:0] + 1'b1};
        default: ;
      endcase
    end
  end

  assign pc_o = pc_q;

  p_cfg_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q[AW-1] && !mode_rst_i) |=> pc_q[AW-1]);
  p_cfg_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_LDCFG) |=> (pc_q == CFG_BASE));
  p_user_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == C_INC && pc_q == USR_TOP) |=> (pc_q == '0));
endmodule

// File: rtl/pgm_latch_bank.sv
module pgm_latch_bank
  import pgm_pkg::*;
#(
  parameter int unsigned DW   = 14,
  parameter int unsigned NLAT = 4,
  localparam int unsigned SW  = $clog2(NLAT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_rst_i,
  input  cmd_e               cmd_i,
  input  logic [SW-1:0]      sel_i,
  input  logic               user_space_i,
  input  logic [DW-1:0]      data_i,
  output logic [NLAT*DW-1:0] lat_o
);
  logic commit_clr;
  assign commit_clr = (cmd_i == C_BEGI || cmd_i == C_BEGE) && user_space_i;

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    logic [DW-1:0] lat_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_q <= '1;
      else if (mode_rst_i) lat_q <= '1;
      else if (cmd_i == C_LDDAT && sel_i == SW'(i)) lat_q <= data_i;
      else if (commit_clr) lat_q <= '1;
    end
    assign lat_o[i*DW +: DW] = lat_q;
  end

  p_lat_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_clr |=> (lat_o == '1));
endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
  import pgm_pkg::*;
#(
  parameter int unsigned PROG_CYC  = 6,
  parameter int unsigned ERASE_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_rst_i,
  input  logic ld_cfg_i,
  input  logic incr_i,
  input  logic ld_data_i,
  input  logic begin_int_i,
  input  logic begin_ext_i,
  input  logic end_pgm_i,
  input  logic row_erase_i,
  input  logic bulk_prog_i,
  input  logic bulk_data_i,
  input  logic code_prot_i,
  input  logic data_prot_i,
  input  logic cfg_space_i,
  output cmd_e cmd_o,
  output logic busy_o,
  output logic wr_active_o
);
  localparam int unsigned MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  state_e        state_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    cmd_o = C_NONE;
    if (!mode_rst_i && state_q == S_IDLE) begin
      if (ld_cfg_i)         cmd_o = C_LDCFG;
      else if (incr_i)      cmd_o = C_INC;
      else if (ld_data_i)   cmd_o = C_LDDAT;
      else if (begin_int_i) cmd_o = C_BEGI;
      else if (begin_ext_i) cmd_o = C_BEGE;
      else if (row_erase_i) cmd_o = (code_prot_i || cfg_space_i) ? C_NONE : C_ROW;
      else if (bulk_prog_i) cmd_o = C_BULKP;
      else if (bulk_data_i) cmd_o = data_prot_i ? C_NONE : C_BULKD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else if (mode_rst_i) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          case (cmd_o)
            C_BEGI: begin state_q <= S_WR_INT; cnt_q <= CW'(PROG_CYC); end
            C_BEGE: state_q <= S_WR_EXT;
            C_ROW, C_BULKP, C_BULKD: begin state_q <= S_ERASE; cnt_q <= CW'(ERASE_CYC); end
            default: ;
          endcase
        end
        S_WR_EXT: if (end_pgm_i) state_q <= S_IDLE;
        default: begin
          if (cnt_q == CW'(1)) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign wr_active_o = (state_q == S_WR_INT) || (state_q == S_WR_EXT);

  p_cnt_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR_INT || state_q == S_ERASE) |-> (cnt_q != '0));
  p_ext_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR_EXT && !end_pgm_i && !mode_rst_i) |=> (state_q == S_WR_EXT));
endmodule

// File: rtl/pgm_req.sv
module pgm_req
  import pgm_pkg::*;
#(
  parameter int unsigned AW      = 14,
  parameter int unsigned DW      = 14,
  parameter int unsigned NLAT    = 4,
  parameter int unsigned ROW_LSB = 4,
  parameter int unsigned ROW_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_rst_i,
  input  cmd_e               cmd_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [NLAT*DW-1:0] lat_i,
  input  logic               data_prot_i,
  output logic               wr_req_o,
  output logic [AW-1:0]      wr_addr_o,
  output logic [NLAT*DW-1:0] wr_data_o,
  output logic               row_erase_o,
  output logic [ROW_W-1:0]   row_sel_o,
  output logic               bulk_erase_o,
  output logic [MASK_W-1:0]  erase_mask_o
);
  localparam int unsigned   SW       = $clog2(NLAT);
  localparam logic [AW-1:0] CFG_BASE = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] CAL0     = CFG_BASE + AW'(8);
  localparam logic [AW-1:0] CAL1     = CFG_BASE + AW'(9);

  logic [MASK_W-1:0] bmask;

  always_comb begin
    bmask = '0;
    bmask[M_PROG] = 1'b1;
    bmask[M_CFGW] = 1'b1;
    if (pc_i == CFG_BASE) bmask[M_UID] = 1'b1;
    if (pc_i == CAL0 || pc_i == CAL1) begin
      bmask[M_UID] = 1'b1;
      bmask[M_CAL] = 1'b1;
    end
    if (data_prot_i) bmask[M_DATA] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_req_o     <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      row_erase_o  <= 1'b0;
      row_sel_o    <= '0;
      bulk_erase_o <= 1'b0;
      erase_mask_o <= '0;
    end else begin
      wr_req_o     <= 1'b0;
      row_erase_o  <= 1'b0;
      bulk_erase_o <= 1'b0;
      if (!mode_rst_i) begin
        case (cmd_i)
          C_BEGI, C_BEGE: begin
            wr_req_o  <= 1'b1;
            wr_addr_o <= {pc_i[AW-1:SW], {SW{1'b0}}};
            wr_data_o <= lat_i;
          end
          C_ROW: begin
            row_erase_o <= 1'b1;
            row_sel_o   <= pc_i[ROW_LSB +: ROW_W];
          end
          C_BULKP: begin
            bulk_erase_o <= 1'b1;
            erase_mask_o <= bmask;
          end
          C_BULKD: begin
            bulk_erase_o <= 1'b1;
            erase_mask_o <= MASK_W'(1) << M_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  p_wr_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> !wr_req_o);
  p_bulk_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bulk_erase_o |=> !bulk_erase_o);
  p_data_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bulk_erase_o && !erase_mask_o[M_PROG]) |-> (erase_mask_o == (MASK_W'(1) << M_DATA)));
endmodule

// File: rtl/pgm_addr_ctrl.sv
module pgm_addr_ctrl
  import pgm_pkg::*;
#(
  parameter int unsigned AW        = 14,
  parameter int unsigned DW        = 14,
  parameter int unsigned NLAT      = 4,
  parameter int unsigned ROW_LSB   = 4,
  parameter int unsigned ROW_W     = 8,
  parameter int unsigned PROG_CYC  = 6,
  parameter int unsigned ERASE_CYC = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_rst_i,
  input  logic               ld_cfg_i,
  input  logic               incr_i,
  input  logic               ld_data_i,
  input  logic [DW-1:0]      data_i,
  input  logic               begin_int_i,
  input  logic               begin_ext_i,
  input  logic               end_pgm_i,
  input  logic               row_erase_i,
  input  logic               bulk_prog_i,
  input  logic               bulk_data_i,
  input  logic               code_prot_i,
  input  logic               data_prot_i,
  output logic [AW-1:0]      pc_o,
  output logic               busy_o,
  output logic               wr_active_o,
  output logic               wr_req_o,
  output logic [AW-1:0]      wr_addr_o,
  output logic [NLAT*DW-1:0] wr_data_o,
  output logic               row_erase_o,
  output logic [ROW_W-1:0]   row_sel_o,
  output logic               bulk_erase_o,
  output logic [MASK_W-1:0]  erase_mask_o
);
  localparam int unsigned SW = $clog2(NLAT);

  cmd_e               cmd;
  logic [NLAT*DW-1:0] lat;

  pgm_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk_i, .rst_ni, .mode_rst_i, .ld_cfg_i, .incr_i, .ld_data_i,
    .begin_int_i, .begin_ext_i, .end_pgm_i, .row_erase_i, .bulk_prog_i,
    .bulk_data_i, .code_prot_i, .data_prot_i,
    .cfg_space_i (pc_o[AW-1]),
    .cmd_o       (cmd),
    .busy_o, .wr_active_o
  );

  pgm_pc #(.AW(AW)) u_pc (
    .clk_i, .rst_ni, .mode_rst_i, .cmd_i(cmd), .pc_o
  );

  pgm_latch_bank #(.DW(DW), .NLAT(NLAT)) u_lat (
    .clk_i, .rst_ni, .mode_rst_i,
    .cmd_i        (cmd),
    .sel_i        (pc_o[SW-1:0]),
    .user_space_i (!pc_o[AW-1]),
    .data_i,
    .lat_o        (lat)
  );

  pgm_req #(.AW(AW), .DW(DW), .NLAT(NLAT), .ROW_LSB(ROW_LSB), .ROW_W(ROW_W)) u_req (
    .clk_i, .rst_ni, .mode_rst_i,
    .cmd_i (cmd),
    .pc_i  (pc_o),
    .lat_i (lat),
    .data_prot_i,
    .wr_req_o, .wr_addr_o, .wr_data_o, .row_erase_o, .row_sel_o,
    .bulk_erase_o, .erase_mask_o
  );

  p_busy_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mode_rst_i) |=> $stable(pc_o));
  p_row_user_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_erase_o |-> !pc_o[AW-1]);
  p_mode_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_rst_i |=> (pc_o == '0 && !busy_o));
endmodule

// File: tb/pgm_addr_ctrl_tb_top.sv
module pgm_addr_ctrl_tb_top;
  localparam int PROG_CYC  = 6;
  localparam int ERASE_CYC = 10;
  localparam int K_LDCFG = 1, K_INC = 2, K_LDDAT = 3, K_BEGI = 4, K_BEGE = 5,
                 K_END = 6, K_ROW = 7, K_BULKP = 8, K_BULKD = 9, K_MRST = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_rst_i = 0, ld_cfg_i = 0, incr_i = 0, ld_data_i = 0;
  logic begin_int_i = 0, begin_ext_i = 0, end_pgm_i = 0;
  logic row_erase_i = 0, bulk_prog_i = 0, bulk_data_i = 0;
  logic code_prot_i = 0, data_prot_i = 0;
  logic [13:0] data_i = '0;
  logic [13:0] pc_o, wr_addr_o;
  logic [55:0] wr_data_o;
  logic [7:0]  row_sel_o;
  logic [4:0]  erase_mask_o;
  logic busy_o, wr_active_o, wr_req_o, row_erase_o, bulk_erase_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  pgm_addr_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (.*);

  // behavioural reference model
  int m_pc, m_st, m_cnt, m_row_sel, m_mask, m_wr_addr;
  int m_lat[4];
  bit m_wr_req, m_row, m_bulk;
  logic [55:0] m_wr_data;

  task automatic model_reset();
    m_pc = 0; m_st = 0; m_cnt = 0; m_row_sel = 0; m_mask = 0; m_wr_addr = 0;
    foreach (m_lat[i]) m_lat[i] = 'h3FFF;
    m_wr_req = 0; m_row = 0; m_bulk = 0; m_wr_data = '0;
  endtask

  task automatic model_step();
    m_wr_req = 0; m_row = 0; m_bulk = 0;
    if (mode_rst_i) begin
      m_pc = 0; m_st = 0; m_cnt = 0;
      foreach (m_lat[i]) m_lat[i] = 'h3FFF;
    end else if (m_st == 2) begin
      if (end_pgm_i) m_st = 0;
    end else if (m_st != 0) begin
      m_cnt--;
      if (m_cnt == 0) m_st = 0;
    end else if (ld_cfg_i) m_pc = 'h2000;
    else if (incr_i) begin
      if (m_pc >= 'h2000) m_pc = 'h2000 + ((m_pc - 'h2000 + 1) % 'h2000);
      else m_pc = (m_pc + 1) % 'h2000;
    end else if (ld_data_i) m_lat[m_pc % 4] = int'(data_i);
    else if (begin_int_i || begin_ext_i) begin
      m_wr_req = 1;
      m_wr_addr = m_pc - (m_pc % 4);
      for (int i = 0; i < 4; i++) m_wr_data[i*14 +: 14] = 14'(m_lat[i]);
      if (m_pc < 'h2000) foreach (m_lat[i]) m_lat[i] = 'h3FFF;
      if (begin_int_i) begin m_st = 1; m_cnt = PROG_CYC; end
      else m_st = 2;
    end else if (row_erase_i) begin
      if (!(code_prot_i || m_pc >= 'h2000)) begin
        m_row = 1; m_row_sel = (m_pc >> 4) & 255; m_st = 3; m_cnt = ERASE_CYC;
      end
    end else if (bulk_prog_i) begin
      m_mask = 3;
      if (m_pc == 'h2000) m_mask |= 4;
      if (m_pc == 'h2008 || m_pc == 'h2009) m_mask |= 12;
      if (data_prot_i) m_mask |= 16;
      m_bulk = 1; m_st = 3; m_cnt = ERASE_CYC;
    end else if (bulk_data_i) begin
      if (!data_prot_i) begin m_mask = 16; m_bulk = 1; m_st = 3; m_cnt = ERASE_CYC; end
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else model_step();
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(pc_o == 14'(m_pc), "R2/R3 pc", 64'(pc_o), 64'(m_pc));
      chk(busy_o == (m_st != 0), "R9 busy", 64'(busy_o), 64'(m_st != 0));
      chk(wr_active_o == (m_st == 1 || m_st == 2), "R10 wr_active", 64'(wr_active_o), 64'(m_st == 1 || m_st == 2));
      chk(wr_req_o == m_wr_req, "R4 wr_req", 64'(wr_req_o), 64'(m_wr_req));
      chk(wr_addr_o == 14'(m_wr_addr), "R4 wr_addr", 64'(wr_addr_o), 64'(m_wr_addr));
      chk(wr_data_o == m_wr_data, "R5 wr_data", 64'(wr_data_o), 64'(m_wr_data));
      chk(row_erase_o == m_row, "R6 row_erase", 64'(row_erase_o), 64'(m_row));
      chk(row_sel_o == 8'(m_row_sel), "R6 row_sel", 64'(row_sel_o), 64'(m_row_sel));
      chk(bulk_erase_o == m_bulk, "R7 bulk", 64'(bulk_erase_o), 64'(m_bulk));
      chk(erase_mask_o == 5'(m_mask), "R8 mask", 64'(erase_mask_o), 64'(m_mask));
    end
  end

  task automatic clr();
    mode_rst_i = 0; ld_cfg_i = 0; incr_i = 0; ld_data_i = 0; begin_int_i = 0;
    begin_ext_i = 0; end_pgm_i = 0; row_erase_i = 0; bulk_prog_i = 0; bulk_data_i = 0;
  endtask

  task automatic set(input int k);
    case (k)
      K_LDCFG: ld_cfg_i = 1;    K_INC:   incr_i = 1;
      K_LDDAT: ld_data_i = 1;   K_BEGI:  begin_int_i = 1;
      K_BEGE:  begin_ext_i = 1; K_END:   end_pgm_i = 1;
      K_ROW:   row_erase_i = 1; K_BULKP: bulk_prog_i = 1;
      K_BULKD: bulk_data_i = 1; K_MRST:  mode_rst_i = 1;
      default: ;
    endcase
  endtask

  // strobe lasts one cycle; returns at the negedge after it was sampled
  task automatic issue(input int k, input logic [13:0] d = '0);
    @(negedge clk_i); clr(); set(k); data_i = d;
    @(negedge clk_i); clr();
  endtask

  task automatic incs(input int n);
    for (int i = 0; i < n; i++) issue(K_INC);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  function automatic int busy_len_dummy(); return 0; endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int blen;
    logic [55:0] exp_d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(pc_o == 0 && !busy_o, "R1 reset state", 64'(pc_o), 0);

    // R4: four loads then internal commit at block 0
    for (int i = 0; i < 4; i++) begin
      issue(K_LDDAT, 14'h0A00 + 14'(i));
      if (i < 3) issue(K_INC);
    end
    issue(K_BEGI);
    exp_d = {14'h0A03, 14'h0A02, 14'h0A01, 14'h0A00};
    chk(wr_req_o && wr_addr_o == 0, "R4 commit addr", 64'(wr_addr_o), 0);
    chk(wr_data_o == exp_d, "R4 commit data", 64'(wr_data_o), 64'(exp_d));
    blen = 0;
    while (busy_o) begin blen++; @(negedge clk_i); end
    chk(blen == PROG_CYC, "R9 write busy length", 64'(blen), 64'(PROG_CYC));

    // R5: user-space commit cleared latches; R9: incr ignored while busy
    issue(K_BEGI);
    chk(wr_data_o == '1, "R5 latches cleared", 64'(wr_data_o), 64'h00FF_FFFF_FFFF_FFFF);
    issue(K_INC);
    wait_idle();
    chk(pc_o == 3, "R9 incr ignored while busy", 64'(pc_o), 3);

    // R6: row erase
    incs(14'h32);
    chk(pc_o == 14'h35, "R2 count", 64'(pc_o), 'h35);
    issue(K_ROW);
    chk(row_erase_o && row_sel_o == 3, "R6 row select", 64'(row_sel_o), 3);
    blen = 0;
    while (busy_o) begin blen++; @(negedge clk_i); end
    chk(blen == ERASE_CYC, "R9 erase busy length", 64'(blen), 64'(ERASE_CYC));
    code_prot_i = 1;
    issue(K_ROW);
    chk(!row_erase_o && !busy_o, "R6 row ignored under protection", 64'(busy_o), 0);
    code_prot_i = 0;

    // R7/R8 user-space bulk masks
    issue(K_BULKP);
    chk(bulk_erase_o && erase_mask_o == 5'h03, "R7 user bulk mask", 64'(erase_mask_o), 3);
    wait_idle();
    data_prot_i = 1;
    issue(K_BULKP);
    chk(erase_mask_o == 5'h13, "R8 bulk with data protect", 64'(erase_mask_o), 'h13);
    wait_idle();
    issue(K_BULKD);
    chk(!bulk_erase_o && !busy_o, "R8 data erase refused", 64'(busy_o), 0);
    data_prot_i = 0;
    issue(K_BULKD);
    chk(bulk_erase_o && erase_mask_o == 5'h10, "R8 data erase mask", 64'(erase_mask_o), 'h10);
    wait_idle();

    // R2 user wrap
    incs(14'h1FFF - 14'h35);
    chk(pc_o == 14'h1FFF, "R2 top of user space", 64'(pc_o), 'h1FFF);
    issue(K_INC);
    chk(pc_o == 0, "R2 user wrap", 64'(pc_o), 0);

    // R4 alignment: loads at 4..7, commit at 7
    incs(4);
    for (int i = 0; i < 4; i++) begin
      issue(K_LDDAT, 14'h1100 + 14'(i));
      if (i < 3) issue(K_INC);
    end
    issue(K_BEGI);
    chk(wr_addr_o == 4, "R4 aligned block address", 64'(wr_addr_o), 4);
    wait_idle();

    // R3 configuration space
    issue(K_LDCFG);
    chk(pc_o == 14'h2000, "R3 load config", 64'(pc_o), 'h2000);
    issue(K_BULKP);
    chk(erase_mask_o == 5'h07, "R7 user-id bulk mask", 64'(erase_mask_o), 7);
    wait_idle();
    issue(K_ROW);
    chk(!row_erase_o && !busy_o, "R6 row ignored in config space", 64'(busy_o), 0);

    // R5 latches kept after config-space commit
    issue(K_LDDAT, 14'h1234);
    issue(K_BEGI);
    exp_d = {14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h1234};
    chk(wr_data_o == exp_d, "R5 config commit data", 64'(wr_data_o), 64'(exp_d));
    wait_idle();
    issue(K_BEGI);
    chk(wr_data_o == exp_d, "R5 latches kept in config space", 64'(wr_data_o), 64'(exp_d));
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      issue(K_LDDAT, 14'h3FFF);
      if (i < 3) issue(K_INC);
    end
    issue(K_BEGI);
    chk(wr_data_o == '1, "R5 latches reset by ones loads", 64'(wr_data_o), 64'h00FF_FFFF_FFFF_FFFF);
    wait_idle();

    // calibration positions
    incs(5);
    issue(K_BULKP);
    chk(erase_mask_o == 5'h0F, "R7 calibration bulk mask 0x2008", 64'(erase_mask_o), 'hF);
    wait_idle();
    issue(K_INC);
    issue(K_BULKP);
    chk(erase_mask_o == 5'h0F, "R7 calibration bulk mask 0x2009", 64'(erase_mask_o), 'hF);
    wait_idle();
    issue(K_INC);
    issue(K_BULKP);
    chk(erase_mask_o == 5'h03, "R7 other config bulk mask", 64'(erase_mask_o), 3);
    wait_idle();

    // R3 config wrap
    incs(14'h3FFF - 14'h200A);
    chk(pc_o == 14'h3FFF, "R3 top of config space", 64'(pc_o), 'h3FFF);
    issue(K_INC);
    chk(pc_o == 14'h2000, "R3 config wrap", 64'(pc_o), 'h2000);

    // R10 externally timed write
    issue(K_BEGE);
    repeat (30) @(negedge clk_i);
    chk(busy_o && wr_active_o, "R10 held until end", 64'(wr_active_o), 1);
    issue(K_END);
    chk(!busy_o && !wr_active_o, "R10 released by end", 64'(busy_o), 0);

    // R11 priority: incr beats load-data
    @(negedge clk_i); clr(); incr_i = 1; ld_data_i = 1; data_i = 14'h0055;
    @(negedge clk_i); clr();
    chk(pc_o == 14'h2001 && !busy_o, "R11 increment wins", 64'(pc_o), 'h2001);
    @(negedge clk_i); clr(); ld_cfg_i = 1; bulk_prog_i = 1;
    @(negedge clk_i); clr();
    chk(pc_o == 14'h2000 && !bulk_erase_o, "R11 load config wins", 64'(pc_o), 'h2000);

    // R1 mode reset aborts erase and returns to user space
    issue(K_BULKP);
    issue(K_MRST);
    chk(pc_o == 0 && !busy_o, "R1 mode reset", 64'(pc_o), 0);
    issue(K_BEGI);
    chk(wr_data_o == '1 && wr_addr_o == 0, "R1 latches reset", 64'(wr_data_o), 64'h00FF_FFFF_FFFF_FFFF);
    wait_idle();
    repeat (2) @(negedge clk_i);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule